// File: doc/BRIEF.md
# Serial Port Register and Interrupt Unit

This block is the processor-facing side of a serial port. A simple read/write strobe bus reaches six word registers: a transmit data port, a receive data port, a control word, a status word, a pair of interrupt fill levels and a baud divisor. Bytes written to the transmit port are queued in a transmit FIFO and offered to a separate framing engine through a valid/ready pair. Bytes delivered by the receive side of that engine, with their parity and framing flags, are queued in a receive FIFO and read back through the receive port.

The status word reports FIFO empty and full conditions, whether the shifter is still sending, and three sticky error flags. A single interrupt line combines a receive condition (enough bytes waiting) and a transmit condition (few enough bytes left) against programmable fill levels. FIFO flushes and the error clear are level bits in the control word: they act on every clock while software holds them at 1 and only stop when software writes them back to 0. The control word and the baud divisor are also driven out to the framing engine and the baud generator.

Top module: `serial_port_regs`

## Requirements
- R1: After reset the control, level and baud registers are zero, `irq` and `tx_valid` are low, and the status word reads 0x0050_0000 (receive empty at bit 20, transmit empty at bit 22).
- R2: Word byte offsets are 0x00 transmit data, 0x04 receive data, 0x08 control (all 32 bits read back), 0x0C status, 0x10 fill levels (bits 15:0 read back), 0x14 baud (low `BAUD_W` bits read back); read data appears on `bus_rdata` one cycle after `bus_rd` and holds until the next read; reads of 0x00 or unmapped offsets return 0.
- R3: A write to 0x00 queues `bus_wdata[7:0]`; `tx_valid` is high while the transmit FIFO is not empty, control bit 12 is 1 and bit 22 is 0; `tx_data` shows the oldest byte and a cycle with `tx_valid` and `tx_ready` both high removes it, in write order.
- R4: A write to 0x00 while the transmit FIFO is full (judged before the clock edge, even if a byte leaves in the same cycle) is dropped and sets status bit 18.
- R5: A byte on `rx_data` with `rx_valid` is stored when control bit 13 is 1 and bit 23 is 0; a read of 0x04 returns the oldest byte in bits 7:0 and removes it; a read with the FIFO empty returns 0; a byte arriving with the receive FIFO full is dropped.
- R6: Status bit 20 is receive FIFO empty, bit 21 transmit FIFO full, bit 22 is transmit FIFO empty and `tx_busy` low, bit 25 follows `tx_busy`; unnamed bits read 0.
- R7: Status bit 16 (parity) and bit 17 (framing) are set by an accepted byte carrying `rx_par_err` or `rx_frm_err`; bits 16 to 18 stay set until control bit 24 is held at 1, which clears them on each clock and takes precedence over a new error in the same cycle.
- R8: While control bit 22 is 1 the transmit FIFO is emptied every clock and writes to 0x00 are discarded; while bit 23 is 1 the receive FIFO is emptied and incoming bytes are discarded.
- R9: The receive interrupt condition is control bits 13 and 27 both 1 and the receive count at or above level bits 7:0.
- R10: The transmit interrupt condition is control bit 28 at 1 and the transmit count at or below level bits 15:8; `irq` is the OR of both conditions.
- R11: `cfg_ctrl` always equals the control register and `cfg_baud` the baud register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| tx_data | output | 8 | Oldest queued transmit byte |
| tx_valid | output | 1 | Transmit byte offered to the framing engine |
| tx_ready | input | 1 | Framing engine takes the offered byte |
| tx_busy | input | 1 | Shifter is still sending |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_par_err | input | 1 | Received byte had a parity error |
| rx_frm_err | input | 1 | Received byte had a framing error |
| cfg_ctrl | output | 32 | Control register contents |
| cfg_baud | output | BAUD_W | Baud divisor register contents |
| irq | output | 1 | Combined interrupt request |

## Verification
Two collisions are provoked on purpose. A bus write to the transmit port is issued in the very cycle the framing engine removes a byte from a full transmit FIFO, and is judged against the rule that fullness is sampled before the edge, so the byte is lost and the write-error flag rises while the count falls by one. A flagged received byte is delivered in the first cycle the error clear is held, and the status word is judged to show no error afterwards, while the byte itself is still queued. A behavioural model of queues and flags is compared with every output on every clock around these events.

// File: rtl/serial_regs_pkg.sv
package serial_regs_pkg;

    // byte offsets of the word registers
    localparam int unsigned OFS_TXD  = 32'h00;
    localparam int unsigned OFS_RXD  = 32'h04;
    localparam int unsigned OFS_CTRL = 32'h08;
    localparam int unsigned OFS_STAT = 32'h0C;
    localparam int unsigned OFS_LVL  = 32'h10;
    localparam int unsigned OFS_BAUD = 32'h14;

    // control word bits
    localparam int CB_TX_EN    = 12;
    localparam int CB_RX_EN    = 13;
    localparam int CB_TX_FLUSH = 22;
    localparam int CB_RX_FLUSH = 23;
    localparam int CB_ERR_CLR  = 24;
    localparam int CB_RX_IE    = 27;
    localparam int CB_TX_IE    = 28;

    // status word bits
    localparam int SB_PAR      = 16;
    localparam int SB_FRM      = 17;
    localparam int SB_WOVF     = 18;
    localparam int SB_RX_EMPTY = 20;
    localparam int SB_TX_FULL  = 21;
    localparam int SB_TX_EMPTY = 22;
    localparam int SB_BUSY     = 25;

    typedef struct packed {
        logic wovf;
        logic frm;
        logic par;
    } err_flags_t;

endpackage

// File: rtl/byte_queue.sv
module byte_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } qstate_t;

    qstate_t q_q, q_d;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign empty = (q_q.cnt == '0);
    assign full  = (q_q.cnt == CW'(DEPTH));
    assign count = q_q.cnt;
    assign head  = mem_q[q_q.rd];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        q_d     = q_q;
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        if (flush) begin
            q_d = '0;
        end else begin
            if (do_push) q_d.wr = step(q_q.wr);
            if (do_pop)  q_d.rd = step(q_q.rd);
            case ({do_push, do_pop})
                2'b10:   q_d.cnt = q_q.cnt + 1'b1;
                2'b01:   q_d.cnt = q_q.cnt - 1'b1;
                default: q_d.cnt = q_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[q_q.wr] <= push_data;
    end

    // R4: occupancy never exceeds the depth
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.cnt <= CW'(DEPTH));

    // R4: a push into a full queue without a pop leaves the count unchanged
    a_r4_full_push_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (count == $past(count)));

endmodule

// File: rtl/fill_irq.sv
module fill_irq #(
    parameter int CW = 7,
    localparam int EW = (CW > 8) ? CW : 8
) (
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    input  logic [7:0]    rx_level,
    input  logic [7:0]    tx_level,
    input  logic          rx_armed,
    input  logic          tx_armed,
    output logic          irq
);

    logic rx_hit, tx_hit;

    always_comb begin
        rx_hit = rx_armed && (EW'(rx_count) >= EW'(rx_level));
        tx_hit = tx_armed && (EW'(tx_count) <= EW'(tx_level));
        irq    = rx_hit || tx_hit;
    end

endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
    import serial_regs_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int BAUD_W = 23,
    parameter int ADDR_W = 5,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic              tx_busy,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    input  logic              rx_par_err,
    input  logic              rx_frm_err,
    output logic [31:0]       cfg_ctrl,
    output logic [BAUD_W-1:0] cfg_baud,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_TXD  = ADDR_W'(OFS_TXD);
    localparam logic [ADDR_W-1:0] A_RXD  = ADDR_W'(OFS_RXD);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_LVL  = ADDR_W'(OFS_LVL);
    localparam logic [ADDR_W-1:0] A_BAUD = ADDR_W'(OFS_BAUD);

    typedef struct packed {
        logic [31:0]       ctrl;
        logic [15:0]       lvl;
        logic [BAUD_W-1:0] baud;
        err_flags_t        err;
        logic [31:0]       rdata;
    } regs_t;

    regs_t s_q, s_d;

    logic [7:0]    tx_head, rx_head;
    logic [CW-1:0] tx_count, rx_count;
    logic          tx_empty, tx_full, rx_empty, rx_full;
    logic          tx_flush, rx_flush, tx_wr, tx_push, tx_pop;
    logic          rx_take, rx_pop;
    logic [31:0]   status_w;

    assign tx_flush = s_q.ctrl[CB_TX_FLUSH];
    assign rx_flush = s_q.ctrl[CB_RX_FLUSH];
    assign tx_wr    = bus_wr && (bus_addr == A_TXD);
    assign tx_push  = tx_wr && !tx_flush;
    assign tx_valid = !tx_empty && s_q.ctrl[CB_TX_EN] && !tx_flush;
    assign tx_pop   = tx_valid && tx_ready;
    assign tx_data  = tx_head;
    assign rx_take  = rx_valid && s_q.ctrl[CB_RX_EN] && !rx_flush;
    assign rx_pop   = bus_rd && (bus_addr == A_RXD);

    byte_queue #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(tx_push), .push_data(bus_wdata[7:0]), .pop(tx_pop),
        .head(tx_head), .count(tx_count), .empty(tx_empty), .full(tx_full)
    );

    byte_queue #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(rx_take), .push_data(rx_data), .pop(rx_pop),
        .head(rx_head), .count(rx_count), .empty(rx_empty), .full(rx_full)
    );

    fill_irq #(.CW(CW)) u_irq (
        .rx_count(rx_count), .tx_count(tx_count),
        .rx_level(s_q.lvl[7:0]), .tx_level(s_q.lvl[15:8]),
        .rx_armed(s_q.ctrl[CB_RX_EN] && s_q.ctrl[CB_RX_IE]),
        .tx_armed(s_q.ctrl[CB_TX_IE]),
        .irq(irq)
    );

    always_comb begin
        status_w              = '0;
        status_w[SB_PAR]      = s_q.err.par;
        status_w[SB_FRM]      = s_q.err.frm;
        status_w[SB_WOVF]     = s_q.err.wovf;
        status_w[SB_RX_EMPTY] = rx_empty;
        status_w[SB_TX_FULL]  = tx_full;
        status_w[SB_TX_EMPTY] = tx_empty && !tx_busy;
        status_w[SB_BUSY]     = tx_busy;
    end

    always_comb begin
        s_d = s_q;

        if (bus_rd) begin
            if (bus_addr == A_RXD)       s_d.rdata = rx_empty ? 32'h0 : {24'h0, rx_head};
            else if (bus_addr == A_CTRL) s_d.rdata = s_q.ctrl;
            else if (bus_addr == A_STAT) s_d.rdata = status_w;
            else if (bus_addr == A_LVL)  s_d.rdata = {16'h0, s_q.lvl};
            else if (bus_addr == A_BAUD) s_d.rdata = 32'(s_q.baud);
            else                         s_d.rdata = 32'h0;
        end

        if (s_q.ctrl[CB_ERR_CLR]) begin
            s_d.err = '0;
        end else begin
            s_d.err.par  = s_q.err.par  | (rx_take && rx_par_err);
            s_d.err.frm  = s_q.err.frm  | (rx_take && rx_frm_err);
            s_d.err.wovf = s_q.err.wovf | (tx_wr && tx_full);
        end

        if (bus_wr) begin
            if (bus_addr == A_CTRL)      s_d.ctrl = bus_wdata;
            else if (bus_addr == A_LVL)  s_d.lvl  = bus_wdata[15:0];
            else if (bus_addr == A_BAUD) s_d.baud = bus_wdata[BAUD_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_rdata = s_q.rdata;
    assign cfg_ctrl  = s_q.ctrl;
    assign cfg_baud  = s_q.baud;

    // R7: a held clear leaves every error flag low after the edge
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ctrl[CB_ERR_CLR] |=> (s_q.err == '0));

    // R4: a write into a full transmit FIFO raises the write-error flag
    a_r4_full_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_full && !s_q.ctrl[CB_ERR_CLR]) |=> s_q.err.wovf);

    // R3: an accepted transmit byte lowers the FIFO count by one
    a_r3_pop_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !tx_wr) |=> (tx_count == CW'($past(tx_count) - 1'b1)));

    // R8: a held receive flush leaves the receive FIFO empty
    a_r8_rx_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> rx_empty);

endmodule

// File: tb/serial_port_regs_test.sv
module serial_port_regs_test;

    localparam int DEPTH  = 64;
    localparam int BAUD_W = 23;
    localparam int ADDR_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [7:0]        tx_data;
    logic              tx_valid;
    logic              tx_ready = 1'b0, tx_busy = 1'b0;
    logic [7:0]        rx_data = '0;
    logic              rx_valid = 1'b0, rx_par_err = 1'b0, rx_frm_err = 1'b0;
    logic [31:0]       cfg_ctrl;
    logic [BAUD_W-1:0] cfg_baud;
    logic              irq;

    int checks = 0, fails = 0;
    bit running = 0, done = 0;

    always #2.5 clk = ~clk;

    serial_port_regs #(.DEPTH(DEPTH), .BAUD_W(BAUD_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_busy(tx_busy),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .cfg_ctrl(cfg_ctrl), .cfg_baud(cfg_baud), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0]  txq[$];
    logic [7:0]  rxq[$];
    logic [31:0] m_ctrl = '0, m_rdata = '0;
    logic [15:0] m_lvl = '0;
    logic [BAUD_W-1:0] m_baud = '0;
    logic [2:0]  m_err = '0;   // [0] parity, [1] framing, [2] write overflow

    function automatic logic [31:0] m_status();
        logic [31:0] s = '0;
        s[16] = m_err[0];
        s[17] = m_err[1];
        s[18] = m_err[2];
        s[20] = (rxq.size() == 0);
        s[21] = (txq.size() == DEPTH);
        s[22] = (txq.size() == 0) && !tx_busy;
        s[25] = tx_busy;
        return s;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            txq.delete(); rxq.delete();
            m_ctrl = '0; m_rdata = '0; m_lvl = '0; m_baud = '0; m_err = '0;
        end else begin
            automatic bit tx_full_pre = (txq.size() == DEPTH);
            automatic bit txv = (txq.size() > 0) && m_ctrl[12] && !m_ctrl[22];
            automatic bit wr_tx = bus_wr && (bus_addr == 5'h00);
            automatic bit rx_take = rx_valid && m_ctrl[13] && !m_ctrl[23];
            automatic bit rx_full_pre = (rxq.size() == DEPTH);
            automatic logic [2:0] newerr;
            if (bus_rd) begin
                case (bus_addr)
                    5'h04:   m_rdata = (rxq.size() > 0) ? {24'h0, rxq[0]} : 32'h0;
                    5'h08:   m_rdata = m_ctrl;
                    5'h0C:   m_rdata = m_status();
                    5'h10:   m_rdata = {16'h0, m_lvl};
                    5'h14:   m_rdata = 32'(m_baud);
                    default: m_rdata = 32'h0;
                endcase
            end
            if (m_ctrl[22]) txq.delete();
            else begin
                if (txv && tx_ready) void'(txq.pop_front());
                if (wr_tx && !tx_full_pre) txq.push_back(bus_wdata[7:0]);
            end
            if (m_ctrl[23]) rxq.delete();
            else begin
                if (bus_rd && bus_addr == 5'h04 && rxq.size() > 0) void'(rxq.pop_front());
                if (rx_take && !rx_full_pre) rxq.push_back(rx_data);
            end
            newerr = {wr_tx && tx_full_pre, rx_take && rx_frm_err, rx_take && rx_par_err};
            if (m_ctrl[24]) m_err = '0;
            else            m_err = m_err | newerr;
            if (bus_wr) begin
                if (bus_addr == 5'h08) m_ctrl = bus_wdata;
                if (bus_addr == 5'h10) m_lvl  = bus_wdata[15:0];
                if (bus_addr == 5'h14) m_baud = bus_wdata[BAUD_W-1:0];
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (running) begin
            automatic bit exp_irq =
                (m_ctrl[13] && m_ctrl[27] && (rxq.size() >= int'(m_lvl[7:0]))) ||
                (m_ctrl[28] && (txq.size() <= int'(m_lvl[15:8])));
            automatic bit exp_txv = (txq.size() > 0) && m_ctrl[12] && !m_ctrl[22];
            check("R2 rdata", bus_rdata, m_rdata);
            check("R10 irq", 32'(irq), 32'(exp_irq));
            check("R3 tx_valid", 32'(tx_valid), 32'(exp_txv));
            if (exp_txv) check("R3 tx_data", 32'(tx_data), 32'(txq[0]));
            check("R11 cfg_ctrl", cfg_ctrl, m_ctrl);
            check("R11 cfg_baud", 32'(cfg_baud), 32'(m_baud));
        end
    end

    // ---------------- stimulus helpers (called at a falling edge) ----------------
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rx_put(input logic [7:0] b, input logic pe, input logic fe);
        rx_valid = 1'b1; rx_data = b; rx_par_err = pe; rx_frm_err = fe;
        @(negedge clk);
        rx_valid = 1'b0; rx_par_err = 1'b0; rx_frm_err = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        running = 1;

        // R1: reset state
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 tx_valid", 32'(tx_valid), 32'h0);
        rd(5'h0C, d); check("R1 status", d, 32'h0050_0000);
        rd(5'h08, d); check("R1 control", d, 32'h0);

        // R2: register map
        wr(5'h08, 32'h0000_3000);
        wr(5'h10, 32'hABCD_0201);
        wr(5'h14, 32'hFFFF_FFFF);
        rd(5'h14, d); check("R2 baud", d, 32'h007F_FFFF);
        rd(5'h10, d); check("R2 levels", d, 32'h0000_0201);
        rd(5'h00, d); check("R2 txport read", d, 32'h0);
        rd(5'h1C, d); check("R2 unmapped", d, 32'h0);
        check("R11 cfg_ctrl", cfg_ctrl, 32'h0000_3000);

        // R3: transmit order and handshake
        wr(5'h00, 32'h0000_0011);
        wr(5'h00, 32'hFFFF_FF22);
        wr(5'h00, 32'h0000_0033);
        check("R3 head", 32'(tx_data), 32'h11);
        tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
        check("R3 next", 32'(tx_data), 32'h22);

        // R4: fill to full, then write in the same cycle as a pop
        for (int i = 0; i < DEPTH - 2; i++) wr(5'h00, 32'(8'h40 + i));
        rd(5'h0C, d); check("R6 tx full", d, 32'h0030_0000);
        tx_ready = 1'b1; wr(5'h00, 32'h0000_00EE); tx_ready = 1'b0;
        rd(5'h0C, d); check("R4 write error", d, 32'h0014_0000);

        // R8: transmit flush held for two cycles, writes discarded
        wr(5'h08, 32'h0040_3000);
        wr(5'h00, 32'h0000_0077);
        wr(5'h08, 32'h0000_3000);
        rd(5'h0C, d); check("R8 tx flushed", d, 32'h0054_0000);

        // R7: sticky parity, clear wins over an error in the same cycle
        rx_put(8'h41, 1'b1, 1'b0);
        rd(5'h0C, d); check("R7 parity set", d, 32'h0045_0000);
        wr(5'h08, 32'h0100_3000);
        rx_put(8'h42, 1'b0, 1'b1);
        wr(5'h08, 32'h0000_3000);
        rd(5'h0C, d); check("R7 cleared", d, 32'h0040_0000);

        // R5: receive order, empty read; R6: busy bit
        rd(5'h04, d); check("R5 first", d, 32'h41);
        rd(5'h04, d); check("R5 second", d, 32'h42);
        tx_busy = 1'b1;
        rd(5'h04, d); check("R5 empty read", d, 32'h0);
        rd(5'h0C, d); check("R6 busy", d, 32'h0210_0000);
        tx_busy = 1'b0;

        // R9: receive level interrupt
        wr(5'h10, 32'h0000_0002);
        wr(5'h08, 32'h0800_3000);
        rx_put(8'h01, 1'b0, 1'b0);
        check("R9 below level", 32'(irq), 32'h0);
        rx_put(8'h02, 1'b0, 1'b0);
        check("R9 at level", 32'(irq), 32'h1);
        rd(5'h04, d);
        check("R9 after read", 32'(irq), 32'h0);

        // R10: transmit level interrupt
        wr(5'h10, 32'h0000_0100);
        wr(5'h08, 32'h1000_3000);
        check("R10 empty", 32'(irq), 32'h1);
        wr(5'h00, 32'h0000_0055);
        wr(5'h00, 32'h0000_0066);
        check("R10 above level", 32'(irq), 32'h0);
        tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
        check("R10 at level", 32'(irq), 32'h1);

        // R5: receive overflow drop, then R8: receive flush
        for (int i = 0; i < DEPTH + 2; i++) rx_put(8'(i + 3), 1'b0, 1'b0);
        rd(5'h04, d); check("R5 oldest kept", d, 32'h02);
        wr(5'h08, 32'h0080_3000);
        rx_put(8'h99, 1'b0, 1'b0);
        wr(5'h08, 32'h0000_3000);
        rd(5'h04, d); check("R8 rx flushed", d, 32'h0);

        repeat (3) @(negedge clk);
        done = 1;
        running = 0;
        summary();
        $finish;
    end

endmodule